// File: doc/BRIEF.md
# Multi-channel power-good qualifier

This block watches four supply channels and decides, for each one, whether the supply may be reported as good. Every channel brings in a digitized monitor voltage together with its own lower (undervoltage) and upper (overvoltage) critical limit. A channel whose voltage sits inside its window starts a millisecond delay counter. The channel's power-good flag is raised only after the chosen delay has run out without the voltage leaving the window. If the voltage leaves the window, the flag drops at once and the count starts over.

Each channel picks one of four delays, 50, 100, 200 or 400 ms, through a two-bit code held in a small register bank on a plain address/data port. The same port reads back a status byte. That byte always shows power-good as active-high, and it also mirrors a live polarity input. The polarity input inverts only the four external power-good outputs. The millisecond timebase comes from the system clock through a parameterized divider.

Top module: `pg_qualifier`

## Requirements
- R1: Channel i is inside its window when uv_lim[i] <= mon_v[i] <= ov_lim[i], with both limits inclusive. If channel i is outside its window at a clock edge, its status bit is 0 after that same edge.
- R2: A 1 ms tick occurs every CLKS_PER_MS clock cycles. Delay code 00 selects 50 ms, 01 selects 100 ms, 10 selects 200 ms and 11 selects 400 ms. Take N as the first edge at which a channel sees itself inside its window, and D as its delay in ms. The channel's status bit then rises no earlier than N+(D-1)*CPM+1 and no later than N+D*CPM+1, as long as the channel stays inside the window.
- R3: A channel that leaves its window while counting restarts. After it re-enters, the full delay must run again before the status bit rises.
- R4: A channel samples its delay code on the first in-window edge. A write to the delay register during a count only affects the next qualification attempt.
- R5: The delay register is at address 0x66 and is read/write. It resets to 0x00. Channel 0 uses bits [1:0], channel 1 uses [3:2], channel 2 uses [5:4] and channel 3 uses [7:6]. In each pair, the higher bit is the upper code bit.
- R6: The status register at address 0x62 is read-only. Bits [3:0] are the channel status bits (1 = good, for any polarity). Bit 5 is the live value of pol_hi. Bits 7, 6 and 4 read 0. Writes to 0x62 change nothing.
- R7: In the same cycle, pg_out[i] equals status bit i when pol_hi=1 and its inverse when pol_hi=0. Changing pol_hi never alters the status bits.
- R8: A read from any address other than 0x62 and 0x66 returns 0x00.
- R9: After reset, all status bits are 0 and all channels wait for their window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_hi | input | 1 | 1 = active-high outputs, 0 = active-low outputs |
| mon_v | input | 4*ADC_W | Monitor voltages, channel i at [i*ADC_W +: ADC_W] |
| uv_lim | input | 4*ADC_W | Lower critical limits, same packing |
| ov_lim | input | 4*ADC_W | Upper critical limits, same packing |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| pg_out | output | 4 | Polarity-adjusted power-good outputs |

## Verification
Register reads and the polarity effect on pg_out are combinational, so the bench checks them later in the same cycle in which it drives the stimulus. A drop out of the window is due one edge later. A rise cannot be tied to one edge, because the free-running tick phase is unknown relative to window entry. Each qualification therefore gets two scoreboard entries: one still-low check at (D-1)*CPM+1 cycles after the drive and one must-be-high check at D*CPM+3 cycles after it. These bracket the legal R2 interval. The bench uses a short CLKS_PER_MS so that 400 ms fits in a few thousand cycles.

// File: rtl/pgq_pkg.sv
package pgq_pkg;

    localparam int NCH       = 4;
    localparam int CODE_W    = 2;
    localparam int MAX_MS    = 400;
    localparam int CNT_W     = $clog2(MAX_MS + 1);
    localparam logic [7:0] ADDR_STAT = 8'h62;
    localparam logic [7:0] ADDR_DLY  = 8'h66;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_GOOD  = 2'd2
    } ch_state_e;

    typedef struct packed {
        ch_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] target;
    } ch_ctx_t;

    typedef struct packed {
        logic [1:0]     spare_hi;
        logic           pol;
        logic           spare_mid;
        logic [NCH-1:0] pg;
    } status_t;

    function automatic logic [CNT_W-1:0] dly_ms(input logic [CODE_W-1:0] code);
        return CNT_W'(50) << code;
    endfunction

endpackage

// File: rtl/pgq_tick.sv
module pgq_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLKS_PER_MS - 1);

    logic [DW-1:0] div;

    always_ff @(posedge clk) begin
        if (rst) begin
            div  <= '0;
            tick <= 1'b0;
        end else if (div == LAST) begin
            div  <= '0;
            tick <= 1'b1;
        end else begin
            div  <= div + 1'b1;
            tick <= 1'b0;
        end
    end

    generate
        if (CLKS_PER_MS > 1) begin : g_chk
            a_r2_tick_isolated: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pgq_channel.sv
module pgq_channel
    import pgq_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADC_W-1:0]  v,
    input  logic [ADC_W-1:0]  uv,
    input  logic [ADC_W-1:0]  ov,
    input  logic [CODE_W-1:0] code,
    output logic              good
);
    ch_ctx_t ctx;
    logic    in_win;

    assign in_win = (v >= uv) && (v <= ov);
    assign good   = (ctx.st == CH_GOOD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.st     <= CH_IDLE;
            ctx.cnt    <= '0;
            ctx.target <= '0;
        end else if (!in_win) begin
            ctx.st  <= CH_IDLE;
            ctx.cnt <= '0;
        end else begin
            unique case (ctx.st)
                CH_IDLE: begin
                    ctx.st     <= CH_COUNT;
                    ctx.cnt    <= '0;
                    ctx.target <= dly_ms(code);
                end
                CH_COUNT: begin
                    if (tick) begin
                        ctx.cnt <= ctx.cnt + 1'b1;
                        if (ctx.cnt == ctx.target - 1'b1)
                            ctx.st <= CH_GOOD;
                    end
                end
                default: ctx.st <= CH_GOOD;
            endcase
        end
    end

    a_r1_leave_clears: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> !good);

    a_r3_rise_needs_window: assert property (@(posedge clk) disable iff (rst)
        $rose(good) |-> $past(in_win));

    a_r4_target_held: assert property (@(posedge clk) disable iff (rst)
        (ctx.st == CH_COUNT) |=> (ctx.st != CH_COUNT) || $stable(ctx.target));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        ctx.cnt <= ctx.target);

endmodule

// File: rtl/pgq_regs.sv
module pgq_regs
    import pgq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    input  logic [NCH-1:0]        good,
    input  logic                  pol_hi,
    output logic [7:0]            rdata,
    output logic [NCH*CODE_W-1:0] codes
);
    logic [7:0] dly_reg;
    status_t    stat;

    always_ff @(posedge clk) begin
        if (rst)
            dly_reg <= 8'h00;
        else if (wr && addr == ADDR_DLY)
            dly_reg <= wdata;
    end

    always_comb begin
        stat           = '0;
        stat.pol       = pol_hi;
        stat.pg        = good;
        unique case (addr)
            ADDR_STAT: rdata = stat;
            ADDR_DLY:  rdata = dly_reg;
            default:   rdata = 8'h00;
        endcase
    end

    assign codes = dly_reg[NCH*CODE_W-1:0];

    a_r5_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dly_reg == 8'h00);

    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_STAT) |=> $stable(dly_reg));

endmodule

// File: rtl/pg_qualifier.sv
module pg_qualifier
    import pgq_pkg::*;
#(
    parameter int ADC_W       = 10,
    parameter int CLKS_PER_MS = 50000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pol_hi,
    input  logic [4*ADC_W-1:0]   mon_v,
    input  logic [4*ADC_W-1:0]   uv_lim,
    input  logic [4*ADC_W-1:0]   ov_lim,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic [3:0]           pg_out
);
    logic                  tick;
    logic [NCH-1:0]        good;
    logic [NCH*CODE_W-1:0] codes;

    pgq_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pgq_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .good   (good),
        .pol_hi (pol_hi),
        .rdata  (reg_rdata),
        .codes  (codes)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            pgq_channel #(.ADC_W(ADC_W)) u_ch (
                .clk  (clk),
                .rst  (rst),
                .tick (tick),
                .v    (mon_v[i*ADC_W +: ADC_W]),
                .uv   (uv_lim[i*ADC_W +: ADC_W]),
                .ov   (ov_lim[i*ADC_W +: ADC_W]),
                .code (codes[i*CODE_W +: CODE_W]),
                .good (good[i])
            );
            assign pg_out[i] = pol_hi ? good[i] : ~good[i];
        end
    endgenerate

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> good == '0);

endmodule

// File: tb/sim_pg_qualifier.sv
module sim_pg_qualifier;

    localparam int ADC_W = 10;
    localparam int CPM   = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pol_hi = 1'b1;
    logic [4*ADC_W-1:0] mon_v = '0;
    logic [4*ADC_W-1:0] uv_lim = '0;
    logic [4*ADC_W-1:0] ov_lim = '0;
    logic               reg_wr = 1'b0;
    logic [7:0]         reg_addr = 8'h62;
    logic [7:0]         reg_wdata = '0;
    logic [7:0]         reg_rdata;
    logic [3:0]         pg_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int    due;
        int    ch;
        logic  exp;
        string tag;
    } exp_t;
    exp_t sbq[$];

    pg_qualifier #(.ADC_W(ADC_W), .CLKS_PER_MS(CPM)) u0 (
        .clk(clk), .rst(rst), .pol_hi(pol_hi), .mon_v(mon_v),
        .uv_lim(uv_lim), .ov_lim(ov_lim), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pg_out(pg_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                checks++;
                if (pg_out[sbq[i].ch] !== sbq[i].exp) begin
                    fails++;
                    $display("FAIL %s ch%0d pg_out actual=%b expected=%b cyc=%0d",
                             sbq[i].tag, sbq[i].ch, pg_out[sbq[i].ch], sbq[i].exp, cyc);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk) #1;
    endtask

    task automatic expect_pg(input int dly, input int ch, input logic e, input string tag);
        exp_t it;
        it.due = cyc + dly; it.ch = ch; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic expect_qual(input int ch, input int ms, input string tag);
        expect_pg(1 + (ms - 1) * CPM, ch, 1'b0, tag);
        expect_pg(ms * CPM + 3, ch, 1'b1, tag);
    endtask

    task automatic set_v(input int ch, input int val);
        mon_v[ch*ADC_W +: ADC_W] = ADC_W'(val);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        step();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = 8'h62;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        step();
        reg_addr = a;
        #5;
        checks++;
        if (reg_rdata !== e) begin
            fails++;
            $display("FAIL %s read 0x%02h actual=0x%02h expected=0x%02h", tag, a, reg_rdata, e);
        end
        reg_addr = 8'h62;
    endtask

    function automatic int uvc(input int ch); return 100 + ch * 10; endfunction
    function automatic int ovc(input int ch); return 800 + ch * 20; endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            uv_lim[c*ADC_W +: ADC_W] = ADC_W'(uvc(c));
            ov_lim[c*ADC_W +: ADC_W] = ADC_W'(ovc(c));
        end
        repeat (5) step();
        rst = 1'b0;

        // R9: cleared after reset, R5 reset value
        for (int c = 0; c < 4; c++) expect_pg(1, c, 1'b0, "R9");
        rd_chk(8'h62, 8'h20, "R9");
        rd_chk(8'h66, 8'h00, "R5");

        // R5: field layout, ch0=00 ch1=01 ch2=10 ch3=11
        wr_reg(8'h66, 8'hE4);
        rd_chk(8'h66, 8'hE4, "R5");

        // R2: all four delays at once
        step();
        for (int c = 0; c < 4; c++) begin
            set_v(c, 500);
            expect_qual(c, 50 << c, "R2");
        end
        repeat (4100) step();
        rd_chk(8'h62, 8'h2F, "R6");

        // R7: polarity flips outputs only
        step();
        pol_hi = 1'b0;
        for (int c = 0; c < 4; c++) expect_pg(0, c, 1'b0, "R7");
        rd_chk(8'h62, 8'h0F, "R7");
        step();
        pol_hi = 1'b1;
        for (int c = 0; c < 4; c++) expect_pg(0, c, 1'b1, "R7");

        // R1: one step past each limit drops status on the next edge
        step();
        set_v(1, ovc(1) + 1);
        set_v(2, uvc(2) - 1);
        expect_pg(1, 1, 1'b0, "R1");
        expect_pg(1, 2, 1'b0, "R1");
        expect_pg(1, 0, 1'b1, "R1");
        expect_pg(1, 3, 1'b1, "R1");
        repeat (3) step();
        rd_chk(8'h62, 8'h29, "R1");

        // R1: exact limits are inside
        step();
        set_v(1, ovc(1));
        set_v(2, uvc(2));
        expect_qual(1, 100, "R1");
        expect_qual(2, 200, "R1");
        repeat (2100) step();
        rd_chk(8'h62, 8'h2F, "R1");

        // R3: interrupted count restarts the full delay
        step();
        set_v(0, 0);
        expect_pg(1, 0, 1'b0, "R3");
        repeat (2) step();
        set_v(0, 500);
        repeat (300) step();
        set_v(0, 0);
        expect_pg(1, 0, 1'b0, "R3");
        step();
        set_v(0, 500);
        expect_qual(0, 50, "R3");
        repeat (600) step();

        // R4: code change mid-count applies to the next attempt only
        step();
        set_v(0, 0);
        step();
        set_v(0, 500);
        expect_qual(0, 50, "R4");
        repeat (5) step();
        wr_reg(8'h66, 8'hE7);
        repeat (600) step();
        set_v(0, 0);
        step();
        set_v(0, 500);
        expect_qual(0, 400, "R4");
        repeat (4100) step();
        rd_chk(8'h66, 8'hE7, "R4");

        // R6: writes to status are ignored
        wr_reg(8'h62, 8'hFF);
        rd_chk(8'h66, 8'hE7, "R6");
        rd_chk(8'h62, 8'h2F, "R6");

        // R8: unmapped addresses
        rd_chk(8'h00, 8'h00, "R8");
        rd_chk(8'h63, 8'h00, "R8");

        repeat (5) step();
        if (sbq.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R2 pending scoreboard entries actual=%0d expected=0", sbq.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule